// File: doc/BRIEF.md
# Debug Execution Control and Breakpoint Unit

This block sits beside a CPU core and decides whether the core may run. A host drives four commands: run, halt, step one instruction, or skip one instruction. The block answers by holding a halt request, a one-instruction step grant, or a skip request that tells the core to move its program counter past the current instruction without committing that instruction's results. After a step or a skip the core is held halted again.

A set of `NBP` breakpoint comparators watches the instruction fetch address and the memory access bus. Every access on that bus carries an address space tag: program, internal data, special registers or external data. Each comparator can fire on a fetch address, or on a read, a write or either kind of access at one address in one space. As an option it can also require a given data byte. A firing comparator sets a sticky status bit. The halt request then takes effect at the next instruction boundary. When no comparator is enabled and the core is running free, the block raises an idle flag so that its surroundings can drop it into a low-power state.

The host configures the block through a plain register write port. For comparator k, address 2k holds the control word and address 2k+1 holds the match value. Address 2·NBP is the status clear register.

Top module: `dbg_exec_ctl`

## Requirements
- R1: After synchronous reset (`rst` high), `halt`, `step_grant`, `skip_req` and `bp_status` are 0, no comparator is enabled and `idle` is 1.
- R2: A command with `cmd_op`=1 (halt) takes effect in any mode. `halt` is 1 from the cycle after the command and stays 1 until run, step or skip is accepted. A halt command also discards a pending breakpoint halt.
- R3: `cmd_op`=0 (run) while halted clears `halt` on the next cycle, and the core then runs until a halt cause occurs.
- R4: `cmd_op`=2 (step) while halted gives `step_grant`=1 and `halt`=0 from the next cycle until a cycle with `insn_done`=1. From the cycle after that boundary, `halt`=1 and `step_grant`=0.
- R5: `cmd_op`=3 (skip) while halted gives `skip_req`=1 and `halt`=0 from the next cycle until the first `insn_done`. After that, `halt`=1 and `skip_req`=0.
- R6: Run, step and skip commands are ignored unless the block is halted.
- R7: A comparator with control kind 0 fires when `fetch_valid` is 1 and `fetch_pc` equals its address field. For a fetch match the space field is ignored.
- R8: Kind 1 fires on writes (`acc_wr`=1), kind 2 on reads, kind 3 on either. Each needs `acc_valid`, an `acc_space` equal to the comparator's space field (0 program, 1 internal data, 2 special registers, 3 external data) and an `acc_addr` equal to its address. Control word layout: bit0 enable, bits2:1 kind, bit3 data compare, bits5:4 space. The match word holds the address in bits AW-1:0 and the data in bits AW+DW-1:AW.
- R9: With the data compare bit set, an access comparator fires only if `acc_data` also equals its data field.
- R10: A comparator that fires sets `bp_status` bit k one cycle later, but only while the block is not halted. Matches that occur while halted change neither status nor mode.
- R11: While running, once a comparator has fired, the first cycle with `insn_done`=1 (the same cycle as the match or a later one) makes `halt` 1 from the next cycle.
- R12: `bp_status` bits are sticky. A write to address 2·NBP clears each bit that is 1 in the written data. A bit that fires in the same cycle stays set.
- R13: `idle` is 1 exactly when the block is in run mode and no comparator is enabled.
- R14: At most one of `halt`, `step_grant`, `skip_req` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 run, 1 halt, 2 step, 3 skip |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CAW | Configuration register address |
| cfg_wdata | input | AW+DW | Configuration write data |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_pc | input | AW | Fetch address |
| insn_done | input | 1 | Instruction boundary strobe |
| acc_valid | input | 1 | Memory access strobe |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_space | input | 2 | Address space tag |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data |
| halt | output | 1 | Halt request to the core |
| step_grant | output | 1 | Core may execute one instruction |
| skip_req | output | 1 | Core must skip the current instruction |
| bp_status | output | NBP | Sticky breakpoint causes |
| idle | output | 1 | No debug activity; low-power hint |

## Verification
The bench goes after near-miss accesses: the right address in the wrong space, the wrong direction for the kind, and the wrong data byte when data compare is on. A design that compared too few fields would halt the core on accesses nobody asked for. It also fires a match in the same cycle as an instruction boundary, and fires another while halted. A design with an off-by-one in the pending logic would let one extra instruction through, and one that watched while halted would set status bits behind the host's back. Step and skip are checked while `insn_done` is held low for several cycles, because a one-shot grant would stall the core. A status clear that lands on a set bit, or that targets a different bit, shows whether write-one-to-clear touches only the named bits.

// File: rtl/dbg_exec_ctl.sv
module dbg_exec_ctl #(
  parameter int AW  = 24,
  parameter int DW  = 8,
  parameter int NBP = 2,
  localparam int CAW = $clog2(2*NBP+1),
  localparam int CW  = AW + DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           fetch_valid,
  input  logic [AW-1:0]  fetch_pc,
  input  logic           insn_done,
  input  logic           acc_valid,
  input  logic           acc_wr,
  input  logic [1:0]     acc_space,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_data,
  output logic           halt,
  output logic           step_grant,
  output logic           skip_req,
  output logic [NBP-1:0] bp_status,
  output logic           idle
);
  localparam logic [CAW-1:0] CLR_ADDR = CAW'(2*NBP);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_STEP, S_SKIP} mode_t;
  mode_t mode;
  logic pend;
  logic [NBP-1:0] hit, en_vec;

  for (genvar k = 0; k < NBP; k++) begin : g_bp
    logic          en, dcmp;
    logic [1:0]    kind, space;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic dir_ok, acc_hit, pc_hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        en <= 1'b0; dcmp <= 1'b0; kind <= '0; space <= '0; addr <= '0; data <= '0;
      end else if (cfg_we && cfg_addr == CAW'(2*k)) begin
        en    <= cfg_wdata[0];
        kind  <= cfg_wdata[2:1];
        dcmp  <= cfg_wdata[3];
        space <= cfg_wdata[5:4];
      end else if (cfg_we && cfg_addr == CAW'(2*k+1)) begin
        addr <= cfg_wdata[AW-1:0];
        data <= cfg_wdata[CW-1:AW];
      end
    end

    assign dir_ok  = (kind == 2'd3) | (kind == 2'd1 & acc_wr) | (kind == 2'd2 & ~acc_wr);
    assign acc_hit = acc_valid & dir_ok & (space == acc_space) & (addr == acc_addr)
                   & (~dcmp | (data == acc_data));
    assign pc_hit  = fetch_valid & (kind == 2'd0) & (addr == fetch_pc);
    assign hit[k]    = en & (pc_hit | acc_hit);
    assign en_vec[k] = en;
  end

  wire live   = (mode != S_HALT);
  wire clr_we = cfg_we && cfg_addr == CLR_ADDR;
  wire [NBP-1:0] clr_mask = clr_we ? cfg_wdata[NBP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) bp_status <= '0;
    else     bp_status <= (bp_status & ~clr_mask) | (live ? hit : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= S_RUN;
      pend <= 1'b0;
    end else if (cmd_valid && cmd_op == 2'd1) begin
      mode <= S_HALT;
      pend <= 1'b0;
    end else begin
      case (mode)
        S_RUN: begin
          if (insn_done && (pend || |hit)) begin
            mode <= S_HALT;
            pend <= 1'b0;
          end else begin
            pend <= pend | (|hit);
          end
        end
        S_HALT: begin
          pend <= 1'b0;
          if (cmd_valid) begin
            case (cmd_op)
              2'd0:    mode <= S_RUN;
              2'd2:    mode <= S_STEP;
              2'd3:    mode <= S_SKIP;
              default: mode <= S_HALT;
            endcase
          end
        end
        default: begin
          pend <= 1'b0;
          if (insn_done) mode <= S_HALT;
        end
      endcase
    end
  end

  assign halt       = (mode == S_HALT);
  assign step_grant = (mode == S_STEP);
  assign skip_req   = (mode == S_SKIP);
  assign idle       = (mode == S_RUN) && (en_vec == '0);

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt, step_grant, skip_req}));                                    // R14
  AST_HALT_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |=> halt);                                    // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halt && !cmd_valid) |=> halt);                                             // R2
  AST_STEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (step_grant && insn_done) |=> (halt && !step_grant));                       // R4
  AST_SKIP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (skip_req && insn_done) |=> (halt && !skip_req));                           // R5
  AST_STEP_WAITS: assert property (@(posedge clk) disable iff (rst)
    (step_grant && !insn_done && !cmd_valid) |=> step_grant);                   // R4
  AST_FROZEN_STATUS: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr_we) |=> (bp_status == $past(bp_status)));                     // R10
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((bp_status & $past(bp_status)) == $past(bp_status)));          // R12
  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (rst)
    idle |-> !(halt || step_grant || skip_req));                                // R13
endmodule

// File: tb/tb_dbg_exec_ctl.sv
module tb_dbg_exec_ctl;
  localparam int AW = 24, DW = 8, NBP = 2;
  localparam int CAW = $clog2(2*NBP+1);

  logic clk = 0, rst = 1;
  logic cmd_valid = 0; logic [1:0] cmd_op = 0;
  logic cfg_we = 0; logic [CAW-1:0] cfg_addr = 0; logic [AW+DW-1:0] cfg_wdata = 0;
  logic fetch_valid = 0; logic [AW-1:0] fetch_pc = 0;
  logic insn_done = 0;
  logic acc_valid = 0, acc_wr = 0; logic [1:0] acc_space = 0;
  logic [AW-1:0] acc_addr = 0; logic [DW-1:0] acc_data = 0;
  logic halt, step_grant, skip_req, idle; logic [NBP-1:0] bp_status;

  dbg_exec_ctl #(.AW(AW), .DW(DW), .NBP(NBP)) dut (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string req = "R1";

  // reference model: 0 run, 1 halted, 2 stepping, 3 skipping
  int m_mode = 0; bit m_pend = 0; bit [NBP-1:0] m_stat = 0;
  bit m_en[NBP]; int m_kind[NBP]; bit m_dc[NBP]; int m_sp[NBP];
  bit [AW-1:0] m_ad[NBP]; bit [DW-1:0] m_da[NBP];

  always @(posedge clk) begin
    bit [NBP-1:0] h;
    cycles++;
    if (rst) begin
      m_mode = 0; m_pend = 0; m_stat = 0;
      for (int k = 0; k < NBP; k++) begin
        m_en[k] = 0; m_kind[k] = 0; m_dc[k] = 0; m_sp[k] = 0; m_ad[k] = 0; m_da[k] = 0;
      end
    end else begin
      h = 0;
      for (int k = 0; k < NBP; k++) begin
        if (m_en[k]) begin
          if (m_kind[k] == 0) h[k] = fetch_valid && fetch_pc == m_ad[k];
          else if (acc_valid && acc_space == m_sp[k] && acc_addr == m_ad[k] &&
                   (!m_dc[k] || acc_data == m_da[k]) &&
                   (m_kind[k] == 3 || (m_kind[k] == 1) == acc_wr)) h[k] = 1;
        end
      end
      if (cfg_we && cfg_addr == 2*NBP) m_stat = m_stat & ~cfg_wdata[NBP-1:0];
      if (m_mode != 1) m_stat = m_stat | h;
      for (int k = 0; k < NBP; k++) begin
        if (cfg_we && cfg_addr == 2*k) begin
          m_en[k] = cfg_wdata[0]; m_kind[k] = cfg_wdata[2:1];
          m_dc[k] = cfg_wdata[3]; m_sp[k] = cfg_wdata[5:4];
        end
        if (cfg_we && cfg_addr == 2*k+1) begin
          m_ad[k] = cfg_wdata[AW-1:0]; m_da[k] = cfg_wdata[AW+DW-1:AW];
        end
      end
      if (cmd_valid && cmd_op == 1) begin m_mode = 1; m_pend = 0; end
      else if (m_mode == 0) begin
        if (h != 0) m_pend = 1;
        if (insn_done && m_pend) begin m_mode = 1; m_pend = 0; end
      end else if (m_mode == 1) begin
        if (cmd_valid && cmd_op != 1) m_mode = (cmd_op == 0) ? 0 : cmd_op;
      end else if (insn_done) m_mode = 1;
    end
  end

  always @(negedge clk) begin
    bit eidle;
    if (!rst) begin
      eidle = (m_mode == 0);
      for (int k = 0; k < NBP; k++) if (m_en[k]) eidle = 0;
      n_cmp++;
      if ({halt, step_grant, skip_req, bp_status, idle} !==
          {m_mode == 1, m_mode == 2, m_mode == 3, m_stat, eidle}) begin
        n_bad++;
        $display("FAIL %s t=%0t halt/step/skip/status/idle actual %b%b%b %b %b expected %b%b%b %b %b",
          req, $time, halt, step_grant, skip_req, bp_status, idle,
          m_mode == 1, m_mode == 2, m_mode == 3, m_stat, eidle);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cmd_valid = 0; cfg_we = 0; fetch_valid = 0; insn_done = 0; acc_valid = 0;
    end
  endtask
  task automatic cmd(input int op);
    cmd_valid = 1; cmd_op = op[1:0]; tick();
  endtask
  task automatic cfg(input int a, input logic [AW+DW-1:0] d);
    cfg_we = 1; cfg_addr = a[CAW-1:0]; cfg_wdata = d; tick();
  endtask
  task automatic acc(input bit wr, input int sp, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit done);
    acc_valid = 1; acc_wr = wr; acc_space = sp[1:0]; acc_addr = a; acc_data = d;
    insn_done = done; tick();
  endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst = 0; #3;
    chk("R1 reset outputs", {halt, step_grant, skip_req, bp_status}, 0);
    chk("R13 idle after reset", idle, 1);

    req = "R2"; cmd(1); tick(3);
    chk("R2 halted", halt, 1);
    req = "R3"; cmd(0); tick();
    chk("R3 running", halt, 0);
    req = "R6"; cmd(2); cmd(3); cmd(0); tick();
    chk("R6 step/skip ignored when running", {step_grant, skip_req, halt}, 0);

    req = "R4"; cmd(1); cmd(2); tick(3);
    chk("R4 grant held", {step_grant, halt}, 2'b10);
    insn_done = 1; tick(); tick();
    chk("R4 halted after one", {step_grant, halt}, 2'b01);
    req = "R5"; cmd(3); tick(2);
    chk("R5 skip held", {skip_req, halt}, 2'b10);
    insn_done = 1; tick();
    chk("R5 halted after skip", {skip_req, halt}, 2'b01);
    req = "R3"; cmd(0);

    req = "R7";
    cfg(0, 32'h0000_0031);            // enable, kind 0, space ignored
    cfg(1, 32'h0000_0100);
    chk("R13 idle low with bp", idle, 0);
    fetch_valid = 1; fetch_pc = 24'h0FF; tick();
    chk("R7 near pc no hit", bp_status, 0);
    fetch_valid = 1; fetch_pc = 24'h100; tick(); tick();
    chk("R7 pc hit status", bp_status, 2'b01);
    req = "R11"; tick(2);
    chk("R11 waits for boundary", halt, 0);
    insn_done = 1; tick();
    chk("R11 halt at boundary", halt, 1);
    req = "R12"; cfg(4, 32'h1); chk("R12 w1c", bp_status, 0);
    cfg(0, 32'h0); req = "R3"; cmd(0);

    req = "R8";
    cfg(2, 32'h0000_0033);            // enable, write, space 3
    cfg(3, 32'h0012_3456);
    acc(0, 3, 24'h123456, 0, 0);
    acc(1, 2, 24'h123456, 0, 0);
    acc(1, 3, 24'h123457, 0, 0);
    chk("R8 near misses", {bp_status, halt}, 0);
    acc(1, 3, 24'h123456, 8'h77, 1); tick();
    chk("R8 write hit, same-cycle boundary halt", {bp_status, halt}, 3'b101);
    req = "R10"; acc(1, 3, 24'h123456, 0, 1); tick();
    cfg(4, 32'h2); acc(1, 3, 24'h123456, 0, 0); tick();
    chk("R10 halted ignores match", {bp_status, halt}, 3'b001);
    req = "R12"; cmd(0); acc(1, 3, 24'h123456, 0, 0);
    cfg_we = 1; cfg_addr = 4; cfg_wdata = 32'h2;
    acc_valid = 1; acc_wr = 1; acc_space = 3; acc_addr = 24'h123456; tick();
    chk("R12 set wins over clear", bp_status, 2'b10);
    req = "R2"; cmd(1); insn_done = 1; tick();
    chk("R2 pending dropped", halt, 1);
    cfg(4, 32'h3); req = "R3"; cmd(0); tick(2);
    chk("R2 no stale halt", halt, 0);

    req = "R9";
    cfg(2, 32'h0000_002D);            // enable, read, data compare, space 2
    cfg(3, 32'h5A00_0080);
    acc(0, 2, 24'h80, 8'h11, 1);
    chk("R9 data mismatch", {bp_status, halt}, 0);
    acc(0, 2, 24'h80, 8'h5A, 0); insn_done = 1; tick(); tick();
    chk("R9 data hit", {bp_status, halt}, 3'b101);
    cfg(4, 32'h3); req = "R3"; cmd(0);

    req = "R8";
    cfg(2, 32'h0000_0017);            // enable, any, space 1
    cfg(3, 32'h0000_0030);
    acc(1, 1, 24'h30, 0, 0); tick();
    chk("R8 any-access hit", bp_status, 2'b10);
    insn_done = 1; tick(); cfg(4, 32'h3); cfg(2, 32'h0);
    req = "R13"; cmd(0); tick();
    chk("R13 idle again", idle, 1);
    tick(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog actual %0d expected <20000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule